// File: doc/BRIEF.md
# Software-Managed TLB Translation Unit

A fully associative translation buffer for a 32-bit embedded core. A request strobe captures an effective address, an access kind, the privilege level, the current process ID and the zone-protection word. In the next cycle every stored entry is compared in parallel. The block answers with one outcome: a translated physical address with its granted read/write rights, a protection fault, an instruction miss or a data miss.

Entries are loaded by software through a write port, one whole entry per cycle. Each entry holds a valid bit, an effective page number, a 3-bit size code, a process-ID tag, an attribute byte whose upper nibble selects a protection zone, a real page number, and execute and write bits. On a miss the block records the faulting address and a syndrome word, which the exception logic then reads.

Top module: `tlb_xlate`

## Requirements
- R1: An entry takes part in matching only while its valid bit is set. Synchronous reset clears every valid bit, and writing an entry with `wr_valid` low removes it from matching.
- R2: A stored process ID of zero matches any current ID. Any other stored ID must equal the `cur_pid` captured with the request.
- R3: Size code s gives a page of 1024·4^s bytes (1 KB to 16 MB). An entry matches when the address bits above the page offset equal its page number. The physical address is the real page number above the offset, OR'd with the request's offset bits.
- R4: When several entries match, the lowest-numbered one alone decides the outcome.
- R5: The zone code of an entry is the 2-bit field of `zone_prot` at bits [31-2z:30-2z], where z is bits [7:4] of the entry's attribute byte. Zone 0 is therefore in bits [31:30].
- R6: Zone code 0 faults every user-mode access (`req_user`=1). In supervisor mode it applies the same entry checks as codes 1 and 2.
- R7: Under zone codes 1 and 2, a fetch (`req_kind`=00) needs the execute bit and a store (`req_kind`=10) needs the write bit; a load (01 or 11) is always allowed. Zone code 3 allows every access.
- R8: On a hit `rsp_rd` is 1, and `rsp_wr` is 1 when the entry's write bit is set or the zone code is 3. On any other outcome `rsp_rd`, `rsp_wr` and `rsp_pa` are 0.
- R9: A miss loads `fault_addr` with the request address and `syndrome` with 0x00800000 for a store or 0 otherwise, visible one cycle after the response. Neither register changes without a miss.
- R10: A response comes exactly one cycle after each strobe, with `rsp_valid` high and exactly one of hit, protection fault, instruction miss (fetch) or data miss (load or store). With no response, all four flags are low.
- R11: Synchronous reset clears `fault_addr` and `syndrome`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup strobe |
| req_ea | input | AW | Effective address |
| req_kind | input | 2 | 00 fetch, 01/11 load, 10 store |
| req_user | input | 1 | User-mode access |
| cur_pid | input | PIDW | Current process ID |
| zone_prot | input | 32 | Zone-protection word, 16 two-bit codes |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IW | Entry index to write |
| wr_valid | input | 1 | Valid bit of the written entry |
| wr_epn | input | AW | Effective page address (low bits masked by size) |
| wr_size | input | 3 | Page size code |
| wr_pid | input | PIDW | Process-ID tag |
| wr_attr | input | 8 | Attribute byte, zone select in [7:4] |
| wr_rpn | input | AW | Real page address |
| wr_exec | input | 1 | Execute permission |
| wr_write | input | 1 | Write permission |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation granted |
| rsp_pa | output | AW | Physical address |
| rsp_rd | output | 1 | Read right granted |
| rsp_wr | output | 1 | Write right granted |
| rsp_prot_fault | output | 1 | Matched entry denies the access |
| rsp_imiss | output | 1 | Instruction fetch missed |
| rsp_dmiss | output | 1 | Data access missed |
| fault_addr | output | AW | Address of the last miss |
| syndrome | output | 32 | Syndrome of the last miss |

## Verification
The bench builds the block with its default values: 64 entries, a 32-bit address and 8-bit process IDs. With these values the size codes reach their full 1 KB to 16 MB range, the highest zone select (15, the lowest two bits of the zone word) can be used, and entries at both ends of the index range can be written. Overlapping entries at distinct indices check the lowest-index rule, and reloading an entry as invalid checks that the next match takes over.

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int ENTRIES = 64,
  parameter int AW      = 32,
  parameter int PIDW    = 8,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_ea,
  input  logic [1:0]      req_kind,
  input  logic            req_user,
  input  logic [PIDW-1:0] cur_pid,
  input  logic [31:0]     zone_prot,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic            wr_valid,
  input  logic [AW-1:0]   wr_epn,
  input  logic [2:0]      wr_size,
  input  logic [PIDW-1:0] wr_pid,
  input  logic [7:0]      wr_attr,
  input  logic [AW-1:0]   wr_rpn,
  input  logic            wr_exec,
  input  logic            wr_write,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic [AW-1:0]   rsp_pa,
  output logic            rsp_rd,
  output logic            rsp_wr,
  output logic            rsp_prot_fault,
  output logic            rsp_imiss,
  output logic            rsp_dmiss,
  output logic [AW-1:0]   fault_addr,
  output logic [31:0]     syndrome
);

  function automatic logic [AW-1:0] page_mask(input logic [2:0] s);
    return {AW{1'b1}} << (5'd10 + {1'b0, s, 1'b0});
  endfunction

  logic            ent_v   [ENTRIES];
  logic [AW-1:0]   ent_epn [ENTRIES];
  logic [AW-1:0]   ent_rpn [ENTRIES];
  logic [2:0]      ent_sz  [ENTRIES];
  logic [PIDW-1:0] ent_pid [ENTRIES];
  logic [3:0]      ent_zs  [ENTRIES];
  logic            ent_ex  [ENTRIES];
  logic            ent_wr  [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) ent_v[i] <= 1'b0;
    end else if (wr_en) begin
      ent_v[wr_idx] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_epn[wr_idx] <= wr_epn & page_mask(wr_size);
      ent_rpn[wr_idx] <= wr_rpn;
      ent_sz[wr_idx]  <= wr_size;
      ent_pid[wr_idx] <= wr_pid;
      ent_zs[wr_idx]  <= wr_attr[7:4];
      ent_ex[wr_idx]  <= wr_exec;
      ent_wr[wr_idx]  <= wr_write;
    end
  end

  logic            req_q, user_q;
  logic [AW-1:0]   ea_q;
  logic [1:0]      kind_q;
  logic [PIDW-1:0] pid_q;
  logic [31:0]     zp_q;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= req_valid;
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      ea_q   <= req_ea;
      kind_q <= req_kind;
      user_q <= req_user;
      pid_q  <= cur_pid;
      zp_q   <= zone_prot;
    end
  end

  logic          hit_any;
  logic [IW-1:0] hit_idx;

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ent_v[i] && (ent_pid[i] == '0 || ent_pid[i] == pid_q) &&
          ((ea_q & page_mask(ent_sz[i])) == ent_epn[i])) begin
        hit_any = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  logic [AW-1:0] sel_mask;
  logic [31:0]   zone_sh;
  logic [1:0]    zcode;
  logic          is_fetch, is_store, allow;

  assign sel_mask = page_mask(ent_sz[hit_idx]);
  assign zone_sh  = zp_q >> (5'd30 - {ent_zs[hit_idx], 1'b0});
  assign zcode    = zone_sh[1:0];
  assign is_fetch = (kind_q == 2'b00);
  assign is_store = (kind_q == 2'b10);
  assign allow    = (zcode == 2'd3) ||
                    (!(zcode == 2'd0 && user_q) &&
                     (is_fetch ? ent_ex[hit_idx] : (!is_store || ent_wr[hit_idx])));

  assign rsp_valid      = req_q;
  assign rsp_hit        = req_q && hit_any && allow;
  assign rsp_prot_fault = req_q && hit_any && !allow;
  assign rsp_imiss      = req_q && !hit_any && is_fetch;
  assign rsp_dmiss      = req_q && !hit_any && !is_fetch;
  assign rsp_rd         = rsp_hit;
  assign rsp_wr         = rsp_hit && (zcode == 2'd3 || ent_wr[hit_idx]);
  assign rsp_pa         = rsp_hit ? ((ent_rpn[hit_idx] & sel_mask) | (ea_q & ~sel_mask)) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_addr <= '0;
      syndrome   <= '0;
    end else if (rsp_imiss || rsp_dmiss) begin
      fault_addr <= ea_q;
      syndrome   <= is_store ? 32'h0080_0000 : 32'h0;
    end
  end

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic          rsp_prot_fault,
  input logic          rsp_imiss,
  input logic          rsp_dmiss,
  input logic          rsp_rd,
  input logic          rsp_wr,
  input logic [AW-1:0] rsp_pa,
  input logic [AW-1:0] fault_addr,
  input logic [31:0]   syndrome,
  input logic [AW-1:0] ea_q,
  input logic [1:0]    kind_q
);

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst) req_valid |=> rsp_valid); // R10
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst) !req_valid |=> !rsp_valid); // R10
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_prot_fault, rsp_imiss, rsp_dmiss}) == 1); // R10
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_prot_fault || rsp_imiss || rsp_dmiss)); // R10
  AST_NOHIT_NORIGHTS: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (!rsp_rd && !rsp_wr && rsp_pa == '0)); // R8
  AST_HIT_READS: assert property (@(posedge clk) disable iff (rst) rsp_hit |-> rsp_rd); // R8
  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (rst)
    (rsp_imiss || rsp_dmiss) |=> fault_addr == $past(ea_q)); // R9
  AST_STORE_SYND: assert property (@(posedge clk) disable iff (rst)
    (rsp_dmiss && kind_q == 2'b10) |=> syndrome == 32'h0080_0000); // R9
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(rsp_imiss || rsp_dmiss) |=> ($stable(fault_addr) && $stable(syndrome))); // R9

endmodule

bind tlb_xlate tlb_xlate_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_prot_fault(rsp_prot_fault), .rsp_imiss(rsp_imiss),
  .rsp_dmiss(rsp_dmiss), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_pa(rsp_pa),
  .fault_addr(fault_addr), .syndrome(syndrome), .ea_q(ea_q), .kind_q(kind_q)
);

// File: tb/test_tlb_xlate.sv
`timescale 1ns/1ps
module test_tlb_xlate;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, req_valid, req_user, wr_en, wr_valid, wr_exec, wr_write;
  logic [31:0] req_ea, zone_prot, wr_epn, wr_rpn;
  logic [1:0]  req_kind;
  logic [7:0]  cur_pid, wr_pid, wr_attr;
  logic [5:0]  wr_idx;
  logic [2:0]  wr_size;
  logic        rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_prot_fault, rsp_imiss, rsp_dmiss;
  logic [31:0] rsp_pa, fault_addr, syndrome;

  tlb_xlate i_tlb_xlate (.*);

  bit          mv   [64];
  logic [31:0] mepn [64], mrpn [64];
  int          msz  [64];
  logic [7:0]  mpid [64], mattr [64];
  bit          mex  [64], mwr [64];
  logic [31:0] x_fa, x_syn;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic put(int idx, bit v, logic [31:0] epn, int sz, logic [7:0] pid,
                     logic [7:0] attr, logic [31:0] rpn, bit ex, bit w);
    wr_en = 1; wr_idx = 6'(idx); wr_valid = v; wr_epn = epn; wr_size = 3'(sz);
    wr_pid = pid; wr_attr = attr; wr_rpn = rpn; wr_exec = ex; wr_write = w;
    @(negedge clk);
    wr_en = 0;
    mv[idx] = v; mepn[idx] = epn; msz[idx] = sz; mpid[idx] = pid;
    mattr[idx] = attr; mrpn[idx] = rpn; mex[idx] = ex; mwr[idx] = w;
    chk("R10 idle", {31'b0, rsp_valid}, 0);
  endtask

  task automatic req(string r, logic [31:0] ea, int kind, bit user);
    int f = -1, sh = 0, z;
    bit ok;
    bit e_hit = 0, e_pf = 0, e_im = 0, e_dm = 0, e_wr = 0;
    logic [31:0] e_pa = 0;
    for (int i = 0; i < 64; i++)
      if (f < 0 && mv[i] && (mpid[i] == 0 || mpid[i] == cur_pid)) begin
        int s = 10 + 2 * msz[i];
        if ((ea >> s) == (mepn[i] >> s)) begin f = i; sh = s; end
      end
    if (f < 0) begin
      e_im = (kind == 0); e_dm = !e_im;
    end else begin
      z = int'((zone_prot >> (30 - 2 * int'(mattr[f] >> 4))) & 3);
      if (z == 3) ok = 1;
      else if (z == 0 && user) ok = 0;
      else if (kind == 0) ok = mex[f];
      else if (kind == 2) ok = mwr[f];
      else ok = 1;
      e_hit = ok; e_pf = !ok;
      if (ok) begin
        e_pa = ((mrpn[f] >> sh) << sh) | (ea & ((32'h1 << sh) - 1));
        e_wr = (z == 3) || mwr[f];
      end
    end
    req_valid = 1; req_ea = ea; req_kind = 2'(kind); req_user = user;
    @(negedge clk);
    req_valid = 0;
    chk({r, " R10 valid"}, {31'b0, rsp_valid}, 1);
    chk({r, " hit"}, {31'b0, rsp_hit}, {31'b0, e_hit});
    chk({r, " protfault"}, {31'b0, rsp_prot_fault}, {31'b0, e_pf});
    chk({r, " R10 imiss"}, {31'b0, rsp_imiss}, {31'b0, e_im});
    chk({r, " R10 dmiss"}, {31'b0, rsp_dmiss}, {31'b0, e_dm});
    chk({r, " R3 pa"}, rsp_pa, e_pa);
    chk({r, " R8 rd"}, {31'b0, rsp_rd}, {31'b0, e_hit});
    chk({r, " R8 wr"}, {31'b0, rsp_wr}, {31'b0, e_wr});
    chk("R9 fault_addr hold", fault_addr, x_fa);
    if (e_im || e_dm) begin
      x_fa = ea; x_syn = (kind == 2) ? 32'h0080_0000 : 32'h0;
    end
    @(negedge clk);
    chk("R10 idle", {31'b0, rsp_valid}, 0);
    chk("R9 fault_addr", fault_addr, x_fa);
    chk("R9 syndrome", syndrome, x_syn);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    for (int i = 0; i < 64; i++) mv[i] = 0;
    x_fa = 0; x_syn = 0;
    chk("R11 fault_addr", fault_addr, 0);
    chk("R11 syndrome", syndrome, 0);
    chk("R10 reset idle", {31'b0, rsp_valid}, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    req_valid = 0; req_ea = 0; req_kind = 0; req_user = 0; cur_pid = 0; zone_prot = 0;
    wr_en = 0; wr_idx = 0; wr_valid = 0; wr_epn = 0; wr_size = 0; wr_pid = 0;
    wr_attr = 0; wr_rpn = 0; wr_exec = 0; wr_write = 0;
    @(negedge clk);
    do_reset();
    req("R1 empty fetch", 32'h0000_1234, 0, 0);

    zone_prot = 32'h1000_0000;                     // zone 1 -> code 1
    put(0, 1, 32'h1000_0000, 1, 0, 8'h10, 32'h8000_0000, 1, 0);
    req("R3 R8 load 4K", 32'h1000_0ABC, 1, 1);
    req("R7 store no wr", 32'h1000_0ABC, 2, 1);
    req("R7 fetch ex", 32'h1000_0004, 0, 1);
    req("R9 load miss", 32'h1000_1000, 1, 0);
    req("R9 store miss", 32'h1000_2008, 2, 0);
    req("R9 fetch miss", 32'h1000_3000, 0, 0);

    put(1, 1, 32'h2000_0000, 0, 8'd5, 8'h10, 32'h0000_4000, 0, 1);
    cur_pid = 5;
    req("R2 pid match", 32'h2000_03FF, 2, 1);
    cur_pid = 6;
    req("R2 pid mismatch", 32'h2000_03FF, 2, 1);
    req("R3 past 1K page", 32'h2000_0400, 1, 1);

    put(2, 1, 32'h4000_0000, 7, 0, 8'h10, 32'h0123_4567, 0, 1);
    req("R3 16M page", 32'h40AB_CDEF, 1, 1);

    put(5, 1, 32'h6000_0000, 1, 0, 8'h10, 32'hA000_0000, 1, 1);
    put(3, 1, 32'h6000_0000, 1, 0, 8'h10, 32'hB000_0000, 0, 0);
    req("R4 lowest index", 32'h6000_0010, 1, 0);
    req("R4 lowest denies", 32'h6000_0010, 2, 0);
    put(3, 0, 32'h6000_0000, 1, 0, 8'h10, 32'hB000_0000, 0, 0);
    req("R1 R4 invalidated", 32'h6000_0010, 2, 0);

    put(63, 1, 32'h7000_0000, 2, 0, 8'hF0, 32'hC000_0000, 0, 0);
    zone_prot = 32'h0000_0003;
    req("R5 R7 zone3 store", 32'h7000_1234, 2, 1);
    zone_prot = 32'h0000_0000;
    req("R6 zone0 user", 32'h7000_1234, 1, 1);
    req("R6 zone0 super", 32'h7000_1234, 1, 0);
    req("R6 zone0 super store", 32'h7000_1234, 2, 0);
    zone_prot = 32'h0000_0002;
    req("R7 zone2 fetch", 32'h7000_1234, 0, 0);
    zone_prot = 32'hC000_0000;                     // zone 0 code 3, zone 15 code 0
    req("R5 zone order", 32'h7000_1234, 2, 1);
    zone_prot = 32'h0000_0001;
    put(10, 1, 32'h9000_0000, 1, 0, 8'hF0, 32'h1000_0000, 1, 0);
    req("R7 zone1 fetch ex", 32'h9000_0010, 0, 1);

    req("R9 miss before reset", 32'hDEAD_0000, 2, 0);
    do_reset();
    req("R1 after reset", 32'h1000_0ABC, 1, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule